// File: doc/BRIEF.md
# Per-Module Clock Mask Controller

This block holds one mask register for each of four clock domains: processor, high-speed bus, and two peripheral buses. Each implemented bit of a mask decides whether one module receives its clock. A module attached to more than one domain owns a bit in each of those domains' masks, and its clock runs only when every one of those bits is set. The clocks are gated by latch-based enable cells. Each cell samples its enable only while the source clock is low, so a mask change cannot cut a high pulse short.

Module register accesses pass through the block. An access aimed at a module whose clock is masked never reaches that module. A read returns zero, a write is dropped, and a one-cycle error pulse is raised.

Two bits are special: the bit for the controller's own clock and the bit for the bus bridge in front of it. Clearing either one freezes all mask registers until the next synchronous reset.

Top module: `cmask_ctrl`

## Requirements
- R1: After reset, every mask register reads 32'hFFFFFFFF, every module clock enable is 1, and every member gated clock toggles.
- R2: Writing 0 to an implemented mask bit stops that module's gated clocks, and writing 1 restarts them. The enable changes in the cycle after the write edge. The gated clock follows from the next rising edge of the domain clock.
- R3: Register address 0 selects the processor mask, 1 the high-speed bus mask, 2 the first peripheral bus mask and 3 the second. Bits 0 to NUM_MOD-1 are implemented. Read data appears one cycle after the address. Writes to bits NUM_MOD and above are ignored, and those bits always read 1.
- R4: A module runs only when all of its member-domain bits are 1. A mask bit in a domain the module does not belong to has no effect on it. The module's gated clock in such a non-member domain stays low.
- R5: Once bit CTRL_BIT of mask CTRL_DOM (default: peripheral bus one, bit 2) or bit BRG_BIT of mask BRG_DOM (default: high-speed bus, bit 7) reads 0, every later mask write is ignored.
- R6: An access to a module whose enable is 0 does not assert that module's request. The cycle after, it returns read data 0 and raises the error output for exactly one cycle.
- R7: An access to an enabled module asserts only that module's request. The cycle after, it returns that module's read data (zero for writes) with no error.
- R8: A synchronous reset clears a lockout and restores all masks to ones, after which writes work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| dom_clk | input | NUM_DOM | Source clock for each domain |
| reg_we | input | 1 | Mask register write strobe |
| reg_addr | input | ADDR_W | Mask register select (domain index) |
| reg_wdata | input | DATA_W | Mask write data |
| reg_rdata | output | DATA_W | Registered mask read data |
| acc_req | input | 1 | Module access request |
| acc_we | input | 1 | Access is a write |
| acc_sel | input | SEL_W | Target module index |
| acc_wdata | input | DATA_W | Access write data |
| acc_rdata | output | DATA_W | Registered access read data |
| acc_err | output | 1 | One-cycle error for an access to a masked module |
| mod_req | output | NUM_MOD | Per-module forwarded request |
| mod_we | output | 1 | Forwarded write flag |
| mod_wdata | output | DATA_W | Forwarded write data |
| mod_rdata | input | NUM_MOD*DATA_W | Read data from each module, module 0 lowest |
| mod_clk_en | output | NUM_MOD | Per-module run enable |
| mod_gclk | output | NUM_DOM*NUM_MOD | Gated clocks, index domain*NUM_MOD+module |

## Verification
The assertions check the following on every cycle:
- The lockout freezes the mask contents.
- A forwarded request is one-hot at most and always targets a clocked module.
- Every error follows a request to a masked module.
- An access to an enabled module never errs.
- All enables are high right after reset.

Only the bench scenarios can show the rest:
- The gated clocks follow the mask on the next clock high phase.
- Unimplemented bits read as one.
- Multi-domain modules combine their bits correctly.
- The correct read data is returned.
- A reset releases a lockout set through either of the two special bits.

// File: rtl/cmask_pkg.sv
package cmask_pkg;
  localparam int NUM_DOM = 4;
  typedef enum logic [1:0] {
    DOM_CPU = 2'd0,
    DOM_HSB = 2'd1,
    DOM_PB1 = 2'd2,
    DOM_PB2 = 2'd3
  } dom_e;
endpackage

// File: rtl/cmask_regs.sv
module cmask_regs #(
  parameter int NUM_DOM  = 4,
  parameter int NUM_MOD  = 8,
  parameter int DATA_W   = 32,
  parameter int CTRL_DOM = 2,
  parameter int CTRL_BIT = 2,
  parameter int BRG_DOM  = 1,
  parameter int BRG_BIT  = 7,
  localparam int ADDR_W  = $clog2(NUM_DOM)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic [NUM_DOM*NUM_MOD-1:0] mask_flat,
  output logic                       locked
);
  logic [NUM_DOM-1:0][NUM_MOD-1:0] mask_q;
  logic [DATA_W-1:0]               rd_word;
  logic                            unused_wr_hi;

  // upper write bits have no storage behind them
  assign unused_wr_hi = ^reg_wdata;

  assign locked = ~mask_q[CTRL_DOM][CTRL_BIT] | ~mask_q[BRG_DOM][BRG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (reg_we && !locked) begin
      mask_q[reg_addr] <= reg_wdata[NUM_MOD-1:0];
    end
  end

  always_comb begin
    rd_word              = '1;
    rd_word[NUM_MOD-1:0] = mask_q[reg_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '1;
    else     reg_rdata <= rd_word;
  end

  assign mask_flat = mask_q;
endmodule

// File: rtl/cmask_enable.sv
module cmask_enable #(
  parameter int NUM_DOM = 4,
  parameter int NUM_MOD = 8,
  parameter logic [NUM_MOD*NUM_DOM-1:0] MEMBER = '1
) (
  input  logic [NUM_DOM*NUM_MOD-1:0] mask_flat,
  output logic [NUM_MOD-1:0]         mod_en,
  output logic [NUM_DOM*NUM_MOD-1:0] gate_en
);
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic [NUM_DOM-1:0] ok;
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      if (MEMBER[m*NUM_DOM+d]) begin : g_mem
        assign ok[d]                  = mask_flat[d*NUM_MOD+m];
        assign gate_en[d*NUM_MOD+m]   = mod_en[m];
      end else begin : g_non
        assign ok[d]                  = 1'b1;
        assign gate_en[d*NUM_MOD+m]   = 1'b0;
      end
    end
    assign mod_en[m] = &ok;
  end
endmodule

// File: rtl/cmask_gate_cell.sv
module cmask_gate_cell (
  input  logic clk_in,
  input  logic en,
  output logic clk_out
);
  logic en_lat;

  // enable is captured only during the low phase of the source clock
  always_latch begin
    if (!clk_in) en_lat <= en;
  end

  assign clk_out = clk_in & en_lat;
endmodule

// File: rtl/cmask_access.sv
module cmask_access #(
  parameter int NUM_MOD = 8,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = $clog2(NUM_MOD)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_MOD-1:0]        mod_en,
  input  logic                      acc_req,
  input  logic                      acc_we,
  input  logic [SEL_W-1:0]          acc_sel,
  input  logic [DATA_W-1:0]         acc_wdata,
  output logic [DATA_W-1:0]         acc_rdata,
  output logic                      acc_err,
  output logic [NUM_MOD-1:0]        mod_req,
  output logic                      mod_we,
  output logic [DATA_W-1:0]         mod_wdata,
  input  logic [NUM_MOD*DATA_W-1:0] mod_rdata
);
  logic              tgt_on;
  logic [DATA_W-1:0] tgt_rdata;

  assign tgt_on    = mod_en[acc_sel];
  assign tgt_rdata = mod_rdata[acc_sel*DATA_W +: DATA_W];
  assign mod_we    = acc_we;
  assign mod_wdata = acc_wdata;

  always_comb begin
    mod_req = '0;
    if (acc_req && tgt_on) mod_req[acc_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      acc_err   <= acc_req & ~tgt_on;
      acc_rdata <= (acc_req && !acc_we && tgt_on) ? tgt_rdata : '0;
    end
  end
endmodule

// File: rtl/cmask_ctrl.sv
module cmask_ctrl
  import cmask_pkg::*;
#(
  parameter int NUM_MOD  = 8,
  parameter int DATA_W   = 32,
  parameter logic [NUM_MOD*NUM_DOM-1:0] MEMBER = 32'h6843_84A1,
  parameter int CTRL_DOM = int'(DOM_PB1),
  parameter int CTRL_BIT = 2,
  parameter int BRG_DOM  = int'(DOM_HSB),
  parameter int BRG_BIT  = 7,
  localparam int SEL_W   = $clog2(NUM_MOD),
  localparam int ADDR_W  = $clog2(NUM_DOM)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_DOM-1:0]        dom_clk,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic                      acc_req,
  input  logic                      acc_we,
  input  logic [SEL_W-1:0]          acc_sel,
  input  logic [DATA_W-1:0]         acc_wdata,
  output logic [DATA_W-1:0]         acc_rdata,
  output logic                      acc_err,
  output logic [NUM_MOD-1:0]        mod_req,
  output logic                      mod_we,
  output logic [DATA_W-1:0]         mod_wdata,
  input  logic [NUM_MOD*DATA_W-1:0] mod_rdata,
  output logic [NUM_MOD-1:0]        mod_clk_en,
  output logic [NUM_DOM*NUM_MOD-1:0] mod_gclk
);
  logic [NUM_DOM*NUM_MOD-1:0] mask_flat;
  logic [NUM_DOM*NUM_MOD-1:0] gate_en;
  logic                       locked;

  cmask_regs #(
    .NUM_DOM(NUM_DOM), .NUM_MOD(NUM_MOD), .DATA_W(DATA_W),
    .CTRL_DOM(CTRL_DOM), .CTRL_BIT(CTRL_BIT),
    .BRG_DOM(BRG_DOM), .BRG_BIT(BRG_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mask_flat(mask_flat), .locked(locked)
  );

  cmask_enable #(
    .NUM_DOM(NUM_DOM), .NUM_MOD(NUM_MOD), .MEMBER(MEMBER)
  ) u_enable (
    .mask_flat(mask_flat), .mod_en(mod_clk_en), .gate_en(gate_en)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dclk
    for (genvar m = 0; m < NUM_MOD; m++) begin : g_cell
      cmask_gate_cell u_cell (
        .clk_in(dom_clk[d]),
        .en(gate_en[d*NUM_MOD+m]),
        .clk_out(mod_gclk[d*NUM_MOD+m])
      );
    end
  end

  cmask_access #(.NUM_MOD(NUM_MOD), .DATA_W(DATA_W)) u_access (
    .clk(clk), .rst(rst), .mod_en(mod_clk_en),
    .acc_req(acc_req), .acc_we(acc_we), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_err(acc_err),
    .mod_req(mod_req), .mod_we(mod_we), .mod_wdata(mod_wdata),
    .mod_rdata(mod_rdata)
  );
endmodule

// File: rtl/cmask_ctrl_chk.sv
module cmask_ctrl_chk #(
  parameter int NUM_DOM = 4,
  parameter int NUM_MOD = 8,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = $clog2(NUM_MOD)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_DOM*NUM_MOD-1:0] mask_flat,
  input logic                       locked,
  input logic                       acc_req,
  input logic [SEL_W-1:0]           acc_sel,
  input logic [DATA_W-1:0]          acc_rdata,
  input logic                       acc_err,
  input logic [NUM_MOD-1:0]         mod_req,
  input logic [NUM_MOD-1:0]         mod_clk_en
);
  assert_reset_all_enabled_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mod_clk_en == '1));

  assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(mask_flat));

  assert_masked_access_err_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !mod_clk_en[acc_sel]) |=> (acc_err && acc_rdata == '0));

  assert_req_needs_clock_R6: assert property (@(posedge clk) disable iff (rst)
    (mod_req & ~mod_clk_en) == '0);

  assert_err_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(acc_req));

  assert_req_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mod_req));

  assert_enabled_no_err_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_req && mod_clk_en[acc_sel]) |=> !acc_err);
endmodule

bind cmask_ctrl cmask_ctrl_chk #(
  .NUM_DOM(cmask_pkg::NUM_DOM), .NUM_MOD(NUM_MOD), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .mask_flat(mask_flat), .locked(locked),
  .acc_req(acc_req), .acc_sel(acc_sel), .acc_rdata(acc_rdata),
  .acc_err(acc_err), .mod_req(mod_req), .mod_clk_en(mod_clk_en)
);

// File: tb/cmask_ctrl_tb_top.sv
`timescale 1ns/100ps
module cmask_ctrl_tb_top;
  localparam int ND = 4;
  localparam int NM = 8;
  localparam int DW = 32;
  localparam logic [NM*ND-1:0] MEMB = 32'h6843_84A1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic acc_req = 1'b0, acc_we = 1'b0;
  logic [2:0] acc_sel = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] acc_rdata;
  logic acc_err;
  logic [NM-1:0] mod_req;
  logic mod_we;
  logic [DW-1:0] mod_wdata;
  logic [NM*DW-1:0] mod_rdata;
  logic [NM-1:0] mod_clk_en;
  logic [ND*NM-1:0] mod_gclk;

  int checks = 0;
  int errors = 0;
  logic [NM-1:0] exp_mask [ND];

  always #2.5 clk = ~clk;

  for (genvar m = 0; m < NM; m++) begin : g_rd
    assign mod_rdata[m*DW +: DW] = 32'hC0DE_0000 | m;
  end

  cmask_ctrl dut_i (
    .clk(clk), .rst(rst), .dom_clk({ND{clk}}),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_req(acc_req), .acc_we(acc_we), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err),
    .mod_req(mod_req), .mod_we(mod_we), .mod_wdata(mod_wdata), .mod_rdata(mod_rdata),
    .mod_clk_en(mod_clk_en), .mod_gclk(mod_gclk)
  );

  function automatic logic exp_en(int m);
    logic r = 1'b1;
    for (int d = 0; d < ND; d++)
      if (MEMB[m*ND+d] && !exp_mask[d][m]) r = 1'b0;
    return r;
  endfunction

  function automatic logic exp_locked();
    return !exp_mask[2][2] || !exp_mask[1][7];
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // called shortly after a rising edge, during the high phase
  task automatic check_clocks(string req);
    for (int m = 0; m < NM; m++) begin
      chk({req, " enable"}, {31'd0, mod_clk_en[m]}, {31'd0, exp_en(m)});
      for (int d = 0; d < ND; d++)
        chk({req, " gclk"}, {31'd0, mod_gclk[d*NM+m]},
            {31'd0, MEMB[m*ND+d] & exp_en(m)});
    end
  endtask

  task automatic read_mask(int d, string req);
    @(negedge clk);
    reg_addr = 2'(d);
    @(posedge clk); #1;
    chk(req, reg_rdata, {24'hFF_FFFF, exp_mask[d]});
  endtask

  task automatic write_mask(int d, logic [DW-1:0] val, string req);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(d); reg_wdata = val;
    if (!exp_locked()) exp_mask[d] = val[NM-1:0];
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    @(posedge clk); #1;
    chk({req, " readback"}, reg_rdata, {24'hFF_FFFF, exp_mask[d]});
    check_clocks(req);
  endtask

  task automatic access(int sel, logic we);
    logic on;
    @(negedge clk);
    acc_req = 1'b1; acc_we = we; acc_sel = 3'(sel); acc_wdata = $urandom;
    on = exp_en(sel);
    #1;
    chk(on ? "R7 req fwd" : "R6 req blocked", {24'd0, mod_req},
        on ? (32'd1 << sel) : 32'd0);
    @(posedge clk); #1;
    chk(on ? "R7 no err" : "R6 err", {31'd0, acc_err}, {31'd0, !on});
    chk(on ? "R7 rdata" : "R6 rdata zero", acc_rdata,
        (on && !we) ? (32'hC0DE_0000 | sel) : 32'd0);
    @(negedge clk);
    acc_req = 1'b0;
    @(posedge clk); #1;
    chk("R6 err one cycle", {31'd0, acc_err}, 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int d = 0; d < ND; d++) exp_mask[d] = '1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [DW-1:0] v;
    int d;
    void'($urandom(32'd1234));
    do_reset();
    @(posedge clk); #1;
    check_clocks("R1 reset");
    for (int i = 0; i < ND; i++) read_mask(i, "R1 reset mask");

    // R2: stop and restart module 0 (processor only)
    write_mask(0, 32'hFFFF_FFFE, "R2 stop");
    access(0, 1'b0);
    write_mask(0, 32'hFFFF_FFFF, "R2 restart");
    access(0, 1'b0);

    // R3: high bits written 0 still read 1
    write_mask(3, 32'h0000_00F7, "R3 high bits");

    // R4: module 1 (HSB+PB2): clear only PB2 bit -> stops; non-member CPU bit 1 no effect
    write_mask(3, 32'hFFFF_FFFD, "R4 multi stop");
    access(1, 1'b0);
    write_mask(3, 32'hFFFF_FFFF, "R4 multi run");
    write_mask(0, 32'hFFFF_FFFD, "R4 non-member");
    access(1, 1'b1);
    write_mask(0, 32'hFFFF_FFFF, "R4 restore");

    // random phase, keeping the two lock bits set
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(1, 0) == 1) begin
        d = $urandom_range(3, 0);
        v = $urandom;
        if (d == 2) v[2] = 1'b1;
        if (d == 1) v[7] = 1'b1;
        write_mask(d, v, "R2 random");
      end else begin
        access($urandom_range(7, 0), 1'($urandom_range(1, 0)));
      end
    end

    // R5: clear controller bit -> locked
    do_reset();
    write_mask(2, 32'hFFFF_FFFB, "R5 lock ctrl");
    write_mask(0, 32'h0000_0000, "R5 write ignored");
    read_mask(0, "R5 mask kept");
    // R8: reset releases
    do_reset();
    read_mask(2, "R8 reset mask");
    write_mask(0, 32'hFFFF_FF0F, "R8 write works");

    // R5: clear bridge bit -> locked
    write_mask(1, 32'hFFFF_FF7F, "R5 lock bridge");
    write_mask(3, 32'h0000_0000, "R5 write ignored bridge");
    write_mask(1, 32'hFFFF_FFFF, "R5 no self unlock");
    do_reset();
    write_mask(3, 32'h0000_00AA, "R8 unlocked");

    summary();
  end
endmodule